// File: doc/BRIEF.md
# Programmable Power-Save Clock Divider

This block lets a processor subsystem slow all of its internal logic by a factor chosen at run time, so that power drops while the clock tree itself keeps running. A small control register holds an enable flag and a two-bit divide code. With the flag clear, the block raises its clock-enable strobe on every cycle. With the flag set, the strobe is raised once in every N cycles. Every consumer that qualifies its flops with the strobe, such as timers or a memory refresh timer, then runs N times slower. A divided clock-out signal is also produced so that the slowed rate can be seen off the block.

Taking an interrupt clears the enable flag on its own, and the subsystem is back at full speed on the next cycle. Software has to write the flag again to go back into power-save. Any write that changes the flag or the divide code restarts the internal prescaler, so the first slowed period after the change is always full length.

Top module: `psave_clkdiv`

## Requirements
- R1: While reset is asserted and after it is released, the register reads 0 (flag clear, code 00), and clk_en is 1 on every cycle.
- R2: A write with wr_en stores wr_data[2] as the enable flag and wr_data[1:0] as the divide code. rd_data returns {flag, code} from the cycle after the write edge.
- R3: While the flag is clear, clk_en is 1 on every cycle and clk_out follows clk.
- R4: With the flag set, divide codes 00, 01, 10 and 11 select N = 1, 2, 4 and 8. clk_en is then high in exactly one cycle out of every N.
- R5: Counting the first cycle after the write edge as cycle 0, clk_en is first high in cycle N-1 after any write that changes the flag or the code. This holds when the code is changed in the middle of a period.
- R6: With the flag set and N of 2 or more, clk_out is high in the first N/2 cycles of each period and low in the rest. This includes the strobe cycle.
- R7: An irq_ack pulse clears the flag at the next edge and keeps the divide code, so clk_en is 1 from the next cycle on. If irq_ack and a write arrive in the same cycle, the flag ends up clear and the code is taken from the write.
- R8: A write that clears the flag restores clk_en to every cycle from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 3 | Bit 2 is the enable flag; bits 1:0 are the divide code |
| rd_data | output | 3 | Current register contents {flag, code} |
| irq_ack | input | 1 | Interrupt-accepted pulse; clears the flag |
| clk_en | output | 1 | Clock-enable strobe for downstream logic |
| clk_out | output | 1 | Observable divided clock |

## Verification
A write or an irq_ack pulse is sampled on one rising edge, and its effect is due in the cycle right after that edge. For a divided setting, the first strobe falls N-1 cycles later. The driver releases each stimulus just after the edge that captures it. It then queues one expected strobe/clock-out pair for each following cycle, numbered from cycle 0. The monitor compares one pair at every falling edge, so each result is sampled half a cycle after the edge that produced it. The follow-the-clock behaviour of clk_out is checked at both clock phases.

// File: rtl/psave_clkdiv.sv
module psave_clkdiv #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W:0]   wr_data,
  output logic [CODE_W:0]   rd_data,
  input  logic              irq_ack,
  output logic              clk_en,
  output logic              clk_out
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic              en_q, en_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [CNT_W-1:0]  cnt_q, last;
  logic [CNT_W:0]    div_n, half;
  logic              restart;

  assign en_d    = irq_ack ? 1'b0 : (wr_en ? wr_data[CODE_W] : en_q);
  assign code_d  = wr_en ? wr_data[CODE_W-1:0] : code_q;
  assign restart = (en_d != en_q) || (code_d != code_q);

  assign div_n = (CNT_W+1)'(1) << code_q;
  assign last  = CNT_W'(div_n - (CNT_W+1)'(1));
  assign half  = div_n >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      code_q <= '0;
      cnt_q  <= '0;
    end else begin
      en_q   <= en_d;
      code_q <= code_d;
      if (restart || !en_q || cnt_q == last) cnt_q <= '0;
      else                                   cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign rd_data = {en_q, code_q};
  assign clk_en  = !en_q || (cnt_q == last);
  assign clk_out = (en_q && code_q != '0) ? ({1'b0, cnt_q} < half) : clk;
endmodule

module psave_clkdiv_chk #(
  parameter int CODE_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [CODE_W:0] wr_data,
  input logic [CODE_W:0] rd_data,
  input logic            irq_ack,
  input logic            clk_en,
  input logic            clk_out
);
  always @(posedge clk) begin
    if (!rst_n) assert_reset_clear_R1: assert (rd_data == '0 && clk_en);
  end

  assert_write_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !irq_ack) |=> (rd_data == $past(wr_data)));

  assert_full_speed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[CODE_W] |-> clk_en);

  assert_no_double_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[CODE_W] && rd_data[CODE_W-1:0] != '0 && clk_en && !wr_en && !irq_ack) |=> !clk_en);

  assert_strobe_low_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[CODE_W] && rd_data[CODE_W-1:0] != '0 && clk_en) |-> !clk_out);

  assert_irq_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (!rd_data[CODE_W] && clk_en));
endmodule

bind psave_clkdiv psave_clkdiv_chk #(.CODE_W(CODE_W)) chk_i (.*);

// File: tb/psave_clkdiv_tb_top.sv
module psave_clkdiv_tb_top;
  typedef struct {
    logic  en;
    logic  co;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_data = '0;
  logic [2:0] rd_data;
  logic       irq_ack = 1'b0;
  logic       clk_en;
  logic       clk_out;

  int   checks = 0;
  int   fails = 0;
  exp_t q[$];
  exp_t it;

  psave_clkdiv dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_ack(irq_ack), .clk_en(clk_en), .clk_out(clk_out));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if (clk_en !== it.en || clk_out !== it.co) begin
        fails++;
        $display("FAIL %s: clk_en/clk_out actual=%b%b expected=%b%b", it.req, clk_en, clk_out, it.en, it.co);
      end
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_div(input int code, input int cycles, input string req);
    int n = 1 << code;
    for (int i = 0; i < cycles; i++) begin
      exp_t e;
      e.en = ((i % n) == n - 1);
      e.co = ((i % n) < n / 2);
      e.req = req;
      q.push_back(e);
    end
  endtask

  task automatic push_full(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      exp_t e;
      e.en = 1'b1;
      e.co = 1'b0;
      e.req = req;
      q.push_back(e);
    end
  endtask

  task automatic drain();
    wait (q.size() == 0);
  endtask

  task automatic reg_write(input logic [2:0] d, input logic irq);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    irq_ack = irq;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    irq_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #12;
    check(rd_data === 3'b000 && clk_en === 1'b1, "R1 during reset", int'({rd_data, clk_en}), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data === 3'b000, "R1 after reset", int'(rd_data), 0);
    push_full(4, "R1 R3 full speed after reset");
    drain();
    @(posedge clk);
    #2;
    check(clk_out === 1'b1, "R3 clk_out follows clk high", int'(clk_out), 1);

    for (int c = 0; c < 4; c++) begin
      reg_write({1'b1, 2'(c)}, 1'b0);
      check(rd_data === {1'b1, 2'(c)}, "R2 readback", int'(rd_data), 4 + c);
      push_div(c, 3 * (1 << c) + 1, "R4 R5 R6 divided pattern");
      drain();
    end

    reg_write(3'b110, 1'b0);
    push_div(2, 2, "R5 before code change");
    drain();
    reg_write(3'b111, 1'b0);
    push_div(3, 16, "R5 restart after mid-period change");
    drain();

    reg_write(3'b000, 1'b0);
    check(rd_data === 3'b000, "R8 readback after disable", int'(rd_data), 0);
    push_full(6, "R8 full speed after disable");
    drain();

    reg_write(3'b111, 1'b0);
    push_div(3, 5, "R7 before interrupt");
    drain();
    irq_ack = 1'b1;
    @(posedge clk);
    #1;
    irq_ack = 1'b0;
    check(rd_data === 3'b011, "R7 flag cleared, code kept", int'(rd_data), 3);
    push_full(6, "R7 full speed after interrupt");
    drain();

    reg_write(3'b110, 1'b1);
    check(rd_data === 3'b010, "R7 irq wins over write", int'(rd_data), 2);
    push_full(5, "R7 R3 still full speed");
    drain();
    @(posedge clk);
    #2;
    check(clk_out === 1'b1, "R3 clk_out follows clk high while disabled", int'(clk_out), 1);

    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule